// File: doc/BRIEF.md
# GPIO Pin Interrupt Sense Unit

This block turns the input levels of a bank of general-purpose pins into two interrupt requests. Each raw pin first passes through a synchroniser chain. For every pin the block keeps the synchronised level from the previous cycle. It then decides, from that pin's configuration bits, whether the pin is pending in this cycle.

A pin is considered only when it is configured as an input and its input path is enabled. An eligible pin can sense in one of three ways: it can follow a level, it can react to one edge, or it can react to any change. In level mode the pin is pending for as long as its level is the opposite of its polarity bit. In edge mode a detected transition sets the pin pending for one cycle only.

Two mask vectors select which pending pins drive request A and which drive request B. Each request follows its mask combinationally. Changing a mask therefore shows on the request output in the same cycle, with no pin activity needed.

Top module: `gpio_irq_sense`

## Requirements
- R1: A change on `pin_raw` reaches the detector after SYNC_STAGES clock edges. The matching `pend_o` bit changes on rising edge SYNC_STAGES+1 after the input change, which is the third edge with the default of 2, and not before.
- R2: A pin whose `cfg_dir` bit is 1 (output) or whose `cfg_inen` bit is 0 never has its `pend_o` bit set. Its level changes do not raise `irq_a` or `irq_b`.
- R3: With `cfg_edge`=1 and `cfg_both`=1, every change of the synchronised level of an eligible pin sets that pin's `pend_o` bit.
- R4: With `cfg_edge`=1 and `cfg_both`=0, `cfg_polar`=0 senses only 0-to-1 transitions and `cfg_polar`=1 senses only 1-to-0 transitions. A transition in the other direction sets nothing.
- R5: In edge mode a detected transition holds the `pend_o` bit high for exactly one clock cycle. When the level does not change, the bit stays low.
- R6: With `cfg_edge`=0, an eligible pin's `pend_o` bit is 1 while its synchronised level differs from its `cfg_polar` bit and 0 otherwise. `cfg_polar`=0 is active-high, `cfg_polar`=1 is active-low, and `cfg_both` has no effect.
- R7: `irq_a` is the OR over all pins of (`pend_o` AND `mask_a`). `irq_b` is the same with `mask_b`. Bit i of every vector belongs to pin i.
- R8: A change of `mask_a` or `mask_b` shows on the matching request in the same cycle, without any clock edge or pin event.
- R9: The previous-level register of a pin follows the synchronised level every cycle, including while the pin is an output or disabled. As a result, making a pin eligible while it is already at its active level produces no edge interrupt.
- R10: While `rst_n` is low, all `pend_o` bits and both requests are 0. All synchroniser and previous-level registers hold 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | NUM_PINS | Unsynchronised pin levels |
| cfg_dir | input | NUM_PINS | 1 = pin is an output (excluded from sensing) |
| cfg_inen | input | NUM_PINS | 1 = input path enabled |
| cfg_edge | input | NUM_PINS | 1 = edge sensing, 0 = level sensing |
| cfg_both | input | NUM_PINS | 1 = any edge (edge mode only) |
| cfg_polar | input | NUM_PINS | Polarity: active-low / falling edge when 1 |
| mask_a | input | NUM_PINS | Pins routed to request A |
| mask_b | input | NUM_PINS | Pins routed to request B |
| pend_o | output | NUM_PINS | Registered per-pin pending state |
| irq_a | output | 1 | Masked interrupt request A |
| irq_b | output | 1 | Masked interrupt request B |

## Verification
The main sweep assigns each pin one of the eight combinations of edge, both and polarity, rotated from pin to pin and from step to step. It drives all four old/new level pairs through every combination. The pending state is checked one cycle before the expected change, on the cycle of the change, and one cycle after it. These three checks tell latency errors apart from edges sensed in the wrong direction and from edge pulses that fail to clear. A one-hot walk of each mask over a settled pending state checks that each request follows its own mask without waiting for a clock. Separate runs with pins set as outputs or disabled check that no pin is sensed there. A further run switches a pin that is already high to an input and checks that no false edge is reported.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   typedef enum logic [1:0] {
      SENSE_LEVEL = 2'd0,
      SENSE_RISE  = 2'd1,
      SENSE_FALL  = 2'd2,
      SENSE_ANY   = 2'd3
   } sense_e;

   // Map the three per-pin configuration bits to a sensing mode.
   function automatic sense_e sense_decode(input logic use_edge,
                                           input logic any_edge,
                                           input logic pol);
      sense_e m;
      if (!use_edge)     m = SENSE_LEVEL;
      else if (any_edge) m = SENSE_ANY;
      else if (pol)      m = SENSE_FALL;
      else               m = SENSE_RISE;
      return m;
   endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
   parameter int WIDTH  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_irq_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q_o = chain[LAST];

endmodule

// File: rtl/gpio_irq_pin_detect.sv
module gpio_irq_pin_detect
   import gpio_irq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   input  logic dir_i,
   input  logic inen_i,
   input  logic edge_i,
   input  logic both_i,
   input  logic polar_i,
   output logic prev_o,
   output logic pend_o
);

   sense_e mode;
   logic   eligible;
   logic   rose;
   logic   fell;
   logic   hit;
   logic   prev_q;
   logic   pend_q;

   assign mode     = sense_decode(edge_i, both_i, polar_i);
   assign eligible = !dir_i && inen_i;
   assign rose     = lvl_i && !prev_q;
   assign fell     = !lvl_i && prev_q;

   always_comb begin
      unique case (mode)
         SENSE_LEVEL: hit = lvl_i ^ polar_i;
         SENSE_RISE:  hit = rose;
         SENSE_FALL:  hit = fell;
         SENSE_ANY:   hit = rose | fell;
         default:     hit = 1'b0;
      endcase
   end

   // The previous level tracks every cycle, so re-enabling never sees a stale edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         prev_q <= lvl_i;
         pend_q <= eligible && hit;
      end
   end

   assign prev_o = prev_q;
   assign pend_o = pend_q;

endmodule

// File: rtl/gpio_irq_combine.sv
module gpio_irq_combine #(
   parameter int WIDTH   = 16,
   parameter int NUM_OUT = 2
) (
   input  logic [WIDTH-1:0]              pend_i,
   input  logic [NUM_OUT-1:0][WIDTH-1:0] mask_i,
   output logic [NUM_OUT-1:0]            irq_o
);

   if (NUM_OUT < 1) begin : g_bad_out
      $error("gpio_irq_combine: NUM_OUT must be at least 1");
   end

   for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
      assign irq_o[o] = |(pend_i & mask_i[o]);
   end

endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense #(
   parameter int NUM_PINS    = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_raw,
   input  logic [NUM_PINS-1:0] cfg_dir,
   input  logic [NUM_PINS-1:0] cfg_inen,
   input  logic [NUM_PINS-1:0] cfg_edge,
   input  logic [NUM_PINS-1:0] cfg_both,
   input  logic [NUM_PINS-1:0] cfg_polar,
   input  logic [NUM_PINS-1:0] mask_a,
   input  logic [NUM_PINS-1:0] mask_b,
   output logic [NUM_PINS-1:0] pend_o,
   output logic                irq_a,
   output logic                irq_b
);

   localparam int NUM_REQ = 2;

   if (NUM_PINS < 1 || NUM_PINS > 64) begin : g_bad_pins
      $error("gpio_irq_sense: NUM_PINS must be 1..64");
   end

   logic [NUM_PINS-1:0]              sync_lvl;
   logic [NUM_PINS-1:0]              prev_lvl;
   logic [NUM_REQ-1:0][NUM_PINS-1:0] req_mask;
   logic [NUM_REQ-1:0]               req;

   gpio_irq_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_raw),
      .q_o   (sync_lvl)
   );

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      gpio_irq_pin_detect i_det (
         .clk     (clk),
         .rst_n   (rst_n),
         .lvl_i   (sync_lvl[p]),
         .dir_i   (cfg_dir[p]),
         .inen_i  (cfg_inen[p]),
         .edge_i  (cfg_edge[p]),
         .both_i  (cfg_both[p]),
         .polar_i (cfg_polar[p]),
         .prev_o  (prev_lvl[p]),
         .pend_o  (pend_o[p])
      );
   end

   assign req_mask[0] = mask_a;
   assign req_mask[1] = mask_b;

   gpio_irq_combine #(
      .WIDTH   (NUM_PINS),
      .NUM_OUT (NUM_REQ)
   ) i_combine (
      .pend_i (pend_o),
      .mask_i (req_mask),
      .irq_o  (req)
   );

   assign irq_a = req[0];
   assign irq_b = req[1];

endmodule

// File: rtl/gpio_irq_sense_chk.sv
module gpio_irq_sense_chk #(
   parameter int NUM_PINS = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_PINS-1:0] cfg_dir,
   input logic [NUM_PINS-1:0] cfg_inen,
   input logic [NUM_PINS-1:0] cfg_edge,
   input logic [NUM_PINS-1:0] cfg_both,
   input logic [NUM_PINS-1:0] cfg_polar,
   input logic [NUM_PINS-1:0] mask_a,
   input logic [NUM_PINS-1:0] mask_b,
   input logic [NUM_PINS-1:0] sync_lvl,
   input logic [NUM_PINS-1:0] prev_lvl,
   input logic [NUM_PINS-1:0] pend_o,
   input logic                irq_a,
   input logic                irq_b
);

   assert_idle_pin_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ((pend_o & $past(cfg_dir | ~cfg_inen)) == '0));

   assert_edge_needs_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ((pend_o & $past(cfg_edge & ~(sync_lvl ^ prev_lvl))) == '0));

   assert_rise_lands_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ((pend_o & $past(cfg_edge & ~cfg_both & ~cfg_polar & ~sync_lvl)) == '0));

   assert_fall_lands_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ((pend_o & $past(cfg_edge & ~cfg_both & cfg_polar & sync_lvl)) == '0));

   assert_level_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (((pend_o ^ $past(~cfg_dir & cfg_inen & (sync_lvl ^ cfg_polar)))
                         & $past(~cfg_edge)) == '0));

   assert_mask_a_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_a == '0) |-> !irq_a);

   assert_mask_b_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_b == '0) |-> !irq_b);

   assert_req_needs_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o == '0) |-> (!irq_a && !irq_b));

   always_comb begin
      if (!rst_n) begin
         assert_reset_quiet_R10: assert (pend_o == '0 || $isunknown(pend_o));
      end
   end

endmodule

bind gpio_irq_sense gpio_irq_sense_chk #(.NUM_PINS(NUM_PINS)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_dir   (cfg_dir),
   .cfg_inen  (cfg_inen),
   .cfg_edge  (cfg_edge),
   .cfg_both  (cfg_both),
   .cfg_polar (cfg_polar),
   .mask_a    (mask_a),
   .mask_b    (mask_b),
   .sync_lvl  (sync_lvl),
   .prev_lvl  (prev_lvl),
   .pend_o    (pend_o),
   .irq_a     (irq_a),
   .irq_b     (irq_b)
);

// File: tb/test_gpio_irq_sense.sv
`timescale 1ns/1ps
module test_gpio_irq_sense;

   localparam int N = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] pin_raw = '0;
   logic [N-1:0] cfg_dir = '0;
   logic [N-1:0] cfg_inen = '0;
   logic [N-1:0] cfg_edge = '0;
   logic [N-1:0] cfg_both = '0;
   logic [N-1:0] cfg_polar = '0;
   logic [N-1:0] mask_a = '0;
   logic [N-1:0] mask_b = '0;
   logic [N-1:0] pend_o;
   logic         irq_a;
   logic         irq_b;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   gpio_irq_sense #(.NUM_PINS(N), .SYNC_STAGES(2)) i_gpio_irq_sense (
      .clk (clk), .rst_n (rst_n), .pin_raw (pin_raw),
      .cfg_dir (cfg_dir), .cfg_inen (cfg_inen), .cfg_edge (cfg_edge),
      .cfg_both (cfg_both), .cfg_polar (cfg_polar),
      .mask_a (mask_a), .mask_b (mask_b),
      .pend_o (pend_o), .irq_a (irq_a), .irq_b (irq_b)
   );

   task automatic check(input string req, input string what,
                        input logic [N-1:0] act, input logic [N-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   // Expected pending bit from the requirements (R3, R4, R5, R6).
   function automatic logic exp_pend(input logic e, input logic b, input logic p,
                                     input logic o, input logic nw, input logic first);
      if (!e)       return nw ^ p;
      if (!first)   return 1'b0;
      if (b)        return o ^ nw;
      if (p)        return o & ~nw;
      return ~o & nw;
   endfunction

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(4 * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [N-1:0] old_v, new_v, e_pre, e_hit, e_after, m;

      // R10: reset state with inputs active
      pin_raw   = '1;
      cfg_inen  = '1;
      mask_a    = '1;
      mask_b    = '1;
      tick(3);
      check("R10", "pend in reset", pend_o, '0);
      check("R10", "irq in reset", {15'd0, irq_a | irq_b}, '0);
      pin_raw = '0;
      rst_n   = 1'b1;
      tick(4);

      // Main sweep: rotate mode and transition per pin.
      for (int k = 0; k < 8; k++) begin
         for (int tr = 0; tr < 4; tr++) begin
            for (int i = 0; i < N; i++) begin
               int md = (i + k) % 8;
               int cd = (i + tr) % 4;
               cfg_polar[i] = md[0];
               cfg_both[i]  = md[1];
               cfg_edge[i]  = md[2];
               old_v[i]     = cd[1];
               new_v[i]     = cd[0];
               e_pre[i]     = cfg_edge[i] ? 1'b0 : (old_v[i] ^ cfg_polar[i]);
               e_hit[i]     = exp_pend(cfg_edge[i], cfg_both[i], cfg_polar[i],
                                       old_v[i], new_v[i], 1'b1);
               e_after[i]   = exp_pend(cfg_edge[i], cfg_both[i], cfg_polar[i],
                                       old_v[i], new_v[i], 1'b0);
            end
            cfg_dir  = '0;
            cfg_inen = '1;
            m        = 16'hA5C3 ^ N'(k * 16'h1111) ^ N'(tr * 16'h0F0F);
            mask_a   = m;
            mask_b   = ~m;
            pin_raw  = old_v;
            tick(4);
            pin_raw = new_v;
            tick(2);
            check("R1", "pend before sync latency", pend_o, e_pre);
            tick(1);
            check("R3/R4/R6 hit R3 R4 R6", "pend on change", pend_o, e_hit);
            check("R7", "irq_a", {15'd0, irq_a}, {15'd0, |(e_hit & m)});
            check("R7", "irq_b", {15'd0, irq_b}, {15'd0, |(e_hit & ~m)});
            tick(1);
            check("R5", "pend one cycle later", pend_o, e_after);
            // R8: walk masks one-hot, no clock in between.
            for (int j = 0; j < N; j++) begin
               mask_a = N'(1) << j;
               mask_b = ~(N'(1) << j);
               #0.5;
               check("R8", "irq_a follows mask", {15'd0, irq_a}, {15'd0, e_after[j]});
               check("R8", "irq_b follows mask", {15'd0, irq_b},
                     {15'd0, |(e_after & ~(N'(1) << j))});
            end
            tick(1);
         end
      end

      // R2: output pins and disabled inputs are never sensed.
      for (int v = 0; v < 2; v++) begin
         cfg_dir   = (v == 0) ? '1 : '0;
         cfg_inen  = (v == 0) ? '1 : '0;
         cfg_edge  = 16'h5555;
         cfg_both  = 16'h5555;
         cfg_polar = '0;
         mask_a    = '1;
         mask_b    = '1;
         pin_raw   = '0;
         tick(4);
         pin_raw = '1;
         tick(3);
         check("R2", "ineligible pend on change", pend_o, '0);
         check("R2", "ineligible irq", {15'd0, irq_a | irq_b}, '0);
         tick(1);
         check("R2", "ineligible pend level", pend_o, '0);
      end

      // R9: switching a high pin to input in rising mode gives no edge.
      cfg_edge  = '1;
      cfg_both  = '0;
      cfg_polar = '0;
      cfg_inen  = '1;
      cfg_dir   = '1;
      pin_raw   = '1;
      tick(4);
      cfg_dir = '0;
      for (int c = 0; c < 4; c++) begin
         tick(1);
         check("R9", "no false edge after enable", pend_o, '0);
      end
      pin_raw = '0;
      tick(4);
      pin_raw = '1;
      tick(3);
      check("R9", "real edge after enable", pend_o, '1);

      finish_run();
   end

endmodule